// File: doc/BRIEF.md
# Round-Robin Thread Issue Controller

This block decides, every clock cycle, which hardware thread feeds a fine-grained multithreaded pipeline, and it holds one program counter per thread. Threads take turns in a fixed rotation, one thread per cycle. The rotation never changes. A thread that cannot make progress still uses its turn. Its PC stays where it was, so the same instruction is fetched again on the thread's next turn. Because of this, the timing of one thread never depends on what the other threads do.

Each issued instruction is followed through the fetch, decode, register-access and execute stages to the memory stage. Three units can ask for a replay:
- the deadline unit, while the instruction is in decode;
- the main-memory arbiter, while it is in execute;
- a multi-cycle ALU operation that has not finished, while it is in execute.

A taken branch supplies its target while the instruction is in execute. At the memory stage the controller writes the thread's new PC. It keeps the old PC if any replay was requested, loads the branch target if a branch was taken, and otherwise adds the fixed increment. With at least five threads, this write always lands before the thread's next turn.

Top module: `rr_issue_ctrl`

## Requirements
- R1: After reset the first cycle issues thread 0. Thread t's PC starts at BOOT_BASE + t*BOOT_STRIDE (defaults 0x1000 and 0x400). During the first rotation every thread issues its boot PC.
- R2: The issued thread ID steps 0, 1, … NUM_THREADS-1, then wraps to 0, one step per cycle. This holds even while every stall input is held high.
- R3: An instruction with no replay request and no taken branch causes the thread's next issue to present PC + PC_INC (default 4).
- R4: `dl_stall_i` high in the cycle an instruction is in decode (one cycle after its issue) makes the thread issue the same PC on its next turn.
- R5: `mem_stall_i` high in the cycle an instruction is in execute (three cycles after its issue) makes the thread issue the same PC on its next turn.
- R6: `alu_busy_i` high during execute replays the instruction. Holding it for several consecutive turns repeats the same PC every turn. The PC advances only after a turn with the ALU released.
- R7: `br_taken_i` high during execute, with no replay request, makes the thread's next issue present `br_target_i` as sampled in that cycle.
- R8: A taken branch on an instruction that is also being replayed is ignored, and the PC is unchanged.
- R9: A replay or branch on one thread leaves the PCs of all other threads unaffected; only the thread whose instruction is at the memory stage can have its PC changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_stall_i | input | 1 | Deadline timer not expired, for the instruction in decode |
| mem_stall_i | input | 1 | Main-memory access not granted, for the instruction in execute |
| alu_busy_i | input | 1 | Multi-cycle ALU operation unfinished, for the instruction in execute |
| br_taken_i | input | 1 | Branch taken by the instruction in execute |
| br_target_i | input | PC_W | Branch target of the instruction in execute |
| issue_tid_o | output | TID_W | Thread issuing this cycle |
| issue_pc_o | output | PC_W | PC of the issuing thread |

## Verification
The bench counts cycles from the cycle in which a thread issues:
- it raises the deadline stall one cycle later, when that instruction is in decode;
- it raises the memory, ALU or branch inputs three cycles later, in execute;
- the PC write falls at the end of the fourth cycle, and the effect is first visible at the thread's next issue, six cycles after the first.

Every task first finds the target thread's issue by watching `issue_tid_o` at a falling edge. It then steps exactly that many falling edges to drive each input for one cycle. Finally it compares `issue_pc_o` at the thread's next issue, and at the next thread's issue for the isolation check.

// File: rtl/rric_pkg.sv
package rric_pkg;

   // Pipeline stage numbering; the distance from fetch decides where
   // each replay cause is sampled and where the PC is written.
   typedef enum logic [2:0] {
      ST_FETCH   = 3'd0,
      ST_DECODE  = 3'd1,
      ST_REGRD   = 3'd2,
      ST_EXECUTE = 3'd3,
      ST_MEM     = 3'd4,
      ST_WB      = 3'd5
   } stage_e;

   localparam int COMMIT_DIST = int'(ST_MEM) - int'(ST_FETCH);

endpackage

// File: rtl/rric_slot_ctr.sv
module rric_slot_ctr #(
   parameter int NT    = 6,
   parameter int TID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TID_W-1:0] slot_o
);

   localparam logic [TID_W-1:0] LAST = TID_W'(NT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot_o <= '0;
      else if (slot_o == LAST)
         slot_o <= '0;
      else
         slot_o <= slot_o + 1'b1;
   end

endmodule

// File: rtl/rric_flight.sv
module rric_flight
   import rric_pkg::*;
#(
   parameter int TID_W = 3,
   parameter int PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] fetch_tid_i,
   input  logic             dl_stall_i,
   input  logic             mem_stall_i,
   input  logic             alu_busy_i,
   input  logic             br_taken_i,
   input  logic [PC_W-1:0]  br_target_i,
   output logic             cm_valid_o,
   output logic [TID_W-1:0] cm_tid_o,
   output logic             cm_replay_o,
   output logic             cm_branch_o,
   output logic [PC_W-1:0]  cm_target_o
);

   localparam int DEPTH  = COMMIT_DIST;
   localparam int DEC_IX = int'(ST_DECODE);
   localparam int EXE_IX = int'(ST_EXECUTE);

   for (genvar s = 0; s <= DEPTH; s++) begin : g_stg
      logic             v;
      logic [TID_W-1:0] tid;
      logic             rep;
      logic             br;
      logic [PC_W-1:0]  tgt;

      if (s == 0) begin : g_fetch
         assign v   = 1'b1;
         assign tid = fetch_tid_i;
         assign rep = 1'b0;
         assign br  = 1'b0;
         assign tgt = '0;
      end else begin : g_reg
         logic            hold_in;
         logic            br_in;
         logic [PC_W-1:0] tgt_in;

         // Replay causes are sampled while the instruction sits in the
         // stage that raises them.
         if (s - 1 == DEC_IX) begin : g_dec_cause
            assign hold_in = dl_stall_i;
         end else if (s - 1 == EXE_IX) begin : g_exe_cause
            assign hold_in = mem_stall_i | alu_busy_i;
         end else begin : g_no_cause
            assign hold_in = 1'b0;
         end

         if (s - 1 == EXE_IX) begin : g_br_cap
            assign br_in  = br_taken_i;
            assign tgt_in = br_target_i;
         end else begin : g_br_pass
            assign br_in  = g_stg[s-1].br;
            assign tgt_in = g_stg[s-1].tgt;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v   <= 1'b0;
               tid <= '0;
               rep <= 1'b0;
               br  <= 1'b0;
               tgt <= '0;
            end else begin
               v   <= g_stg[s-1].v;
               tid <= g_stg[s-1].tid;
               rep <= g_stg[s-1].rep | hold_in;
               br  <= br_in;
               tgt <= tgt_in;
            end
         end
      end
   end

   assign cm_valid_o  = g_stg[DEPTH].v;
   assign cm_tid_o    = g_stg[DEPTH].tid;
   assign cm_replay_o = g_stg[DEPTH].rep;
   assign cm_branch_o = g_stg[DEPTH].br;
   assign cm_target_o = g_stg[DEPTH].tgt;

endmodule

// File: rtl/rric_pc_bank.sv
module rric_pc_bank #(
   parameter int              NT          = 6,
   parameter int              TID_W       = 3,
   parameter int              PC_W        = 32,
   parameter int              PC_INC      = 4,
   parameter logic [PC_W-1:0] BOOT_BASE   = 32'h0000_1000,
   parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0400
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cm_valid_i,
   input  logic [TID_W-1:0]         cm_tid_i,
   input  logic                     cm_replay_i,
   input  logic                     cm_branch_i,
   input  logic [PC_W-1:0]          cm_target_i,
   input  logic [TID_W-1:0]         rd_tid_i,
   output logic [PC_W-1:0]          rd_pc_o,
   output logic [NT-1:0][PC_W-1:0]  pc_all_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(PC_INC);

   for (genvar t = 0; t < NT; t++) begin : g_thr
      localparam logic [PC_W-1:0] BOOT_PC = BOOT_BASE + PC_W'(t) * BOOT_STRIDE;
      logic [PC_W-1:0] q;
      logic            wr;

      assign wr = cm_valid_i && !cm_replay_i && (cm_tid_i == TID_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= BOOT_PC;
         else if (wr)
            q <= cm_branch_i ? cm_target_i : q + STEP;
      end

      assign pc_all_o[t] = q;
   end

   assign rd_pc_o = pc_all_o[rd_tid_i];

endmodule

// File: rtl/rr_issue_ctrl.sv
module rr_issue_ctrl
   import rric_pkg::*;
#(
   parameter int              NUM_THREADS = 6,
   parameter int              PC_W        = 32,
   parameter int              PC_INC      = 4,
   parameter logic [PC_W-1:0] BOOT_BASE   = 32'h0000_1000,
   parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0400,
   localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dl_stall_i,
   input  logic             mem_stall_i,
   input  logic             alu_busy_i,
   input  logic             br_taken_i,
   input  logic [PC_W-1:0]  br_target_i,
   output logic [TID_W-1:0] issue_tid_o,
   output logic [PC_W-1:0]  issue_pc_o
);

   // The PC write must land before the same thread's next turn.
   if (NUM_THREADS <= COMMIT_DIST) begin : g_bad_threads
      $error("rr_issue_ctrl: NUM_THREADS must exceed the fetch-to-memory distance");
   end
   if (PC_INC <= 0) begin : g_bad_inc
      $error("rr_issue_ctrl: PC_INC must be positive");
   end
   if (PC_W < 2) begin : g_bad_pcw
      $error("rr_issue_ctrl: PC_W too small");
   end

   logic                            cm_valid;
   logic [TID_W-1:0]                cm_tid;
   logic                            cm_replay;
   logic                            cm_branch;
   logic [PC_W-1:0]                 cm_target;
   logic [NUM_THREADS-1:0][PC_W-1:0] pc_all;

   rric_slot_ctr #(
      .NT    (NUM_THREADS),
      .TID_W (TID_W)
   ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_o (issue_tid_o)
   );

   rric_flight #(
      .TID_W (TID_W),
      .PC_W  (PC_W)
   ) u_flight (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_tid_i (issue_tid_o),
      .dl_stall_i  (dl_stall_i),
      .mem_stall_i (mem_stall_i),
      .alu_busy_i  (alu_busy_i),
      .br_taken_i  (br_taken_i),
      .br_target_i (br_target_i),
      .cm_valid_o  (cm_valid),
      .cm_tid_o    (cm_tid),
      .cm_replay_o (cm_replay),
      .cm_branch_o (cm_branch),
      .cm_target_o (cm_target)
   );

   rric_pc_bank #(
      .NT          (NUM_THREADS),
      .TID_W       (TID_W),
      .PC_W        (PC_W),
      .PC_INC      (PC_INC),
      .BOOT_BASE   (BOOT_BASE),
      .BOOT_STRIDE (BOOT_STRIDE)
   ) u_pcs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cm_valid_i  (cm_valid),
      .cm_tid_i    (cm_tid),
      .cm_replay_i (cm_replay),
      .cm_branch_i (cm_branch),
      .cm_target_i (cm_target),
      .rd_tid_i    (issue_tid_o),
      .rd_pc_o     (issue_pc_o),
      .pc_all_o    (pc_all)
   );

endmodule

// File: rtl/rr_issue_ctrl_chk.sv
module rr_issue_ctrl_chk #(
   parameter int NT     = 6,
   parameter int TID_W  = 3,
   parameter int PC_W   = 32,
   parameter int PC_INC = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [TID_W-1:0]        issue_tid,
   input logic                    cm_valid,
   input logic [TID_W-1:0]        cm_tid,
   input logic                    cm_replay,
   input logic                    cm_branch,
   input logic [PC_W-1:0]         cm_target,
   input logic [NT-1:0][PC_W-1:0] pc_all
);

   // R2
   rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> issue_tid == (($past(issue_tid) == TID_W'(NT - 1)) ? '0 : $past(issue_tid) + 1'b1));

   for (genvar t = 0; t < NT; t++) begin : g_thr_chk
      // R9
      other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(cm_valid && cm_tid == TID_W'(t)) |=> $stable(pc_all[t]));

      // R4 R5 R6 R8
      replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cm_valid && cm_tid == TID_W'(t) && cm_replay) |=> $stable(pc_all[t]));

      // R3
      seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cm_valid && cm_tid == TID_W'(t) && !cm_replay && !cm_branch)
            |=> pc_all[t] == $past(pc_all[t]) + PC_W'(PC_INC));

      // R7
      branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cm_valid && cm_tid == TID_W'(t) && !cm_replay && cm_branch)
            |=> pc_all[t] == $past(cm_target));
   end

endmodule

bind rr_issue_ctrl rr_issue_ctrl_chk #(
   .NT     (NUM_THREADS),
   .TID_W  (TID_W),
   .PC_W   (PC_W),
   .PC_INC (PC_INC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_tid (issue_tid_o),
   .cm_valid  (cm_valid),
   .cm_tid    (cm_tid),
   .cm_replay (cm_replay),
   .cm_branch (cm_branch),
   .cm_target (cm_target),
   .pc_all    (pc_all)
);

// File: tb/rr_issue_ctrl_tb.sv
module rr_issue_ctrl_tb;

   localparam int          NT    = 6;
   localparam int          PC_W  = 32;
   localparam int          TID_W = 3;
   localparam logic [31:0] BASE  = 32'h0000_1000;
   localparam logic [31:0] STRD  = 32'h0000_0400;
   localparam logic [31:0] INC   = 32'd4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             dl_stall = 1'b0;
   logic             mem_stall = 1'b0;
   logic             alu_busy = 1'b0;
   logic             br_taken = 1'b0;
   logic [PC_W-1:0]  br_target = '0;
   logic [TID_W-1:0] tid;
   logic [PC_W-1:0]  pc;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rr_issue_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .dl_stall_i  (dl_stall),
      .mem_stall_i (mem_stall),
      .alu_busy_i  (alu_busy),
      .br_taken_i  (br_taken),
      .br_target_i (br_target),
      .issue_tid_o (tid),
      .issue_pc_o  (pc)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_issue(input int t);
      @(negedge clk);
      while (tid != TID_W'(t)) @(negedge clk);
   endtask

   // R1: first rotation after reset presents every boot PC, thread 0 first
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int t = 0; t < NT; t++) begin
         check(tid == TID_W'(t), "R1 tid", 32'(tid), t);
         check(pc == BASE + STRD * t, "R1 boot pc", pc, BASE + STRD * t);
         @(negedge clk);
      end
   endtask

   // R2 + R3: free-running rotation, each PC moves by the increment
   task automatic t_rotation();
      logic [31:0] seen [NT];
      wait_issue(0);
      for (int t = 0; t < NT; t++) begin
         seen[t] = pc;
         if (t < NT - 1) @(negedge clk);
      end
      for (int t = 0; t < NT; t++) begin
         @(negedge clk);
         check(tid == TID_W'(t), "R2 order", 32'(tid), t);
         check(pc == seen[t] + INC, "R3 advance", pc, seen[t] + INC);
      end
   endtask

   // R4 (stage 1) / R5 (stage 3) single replay plus R9 on the neighbour
   task automatic t_stall(input int t, input int stage, input string req);
      logic [31:0] p0, pn;
      wait_issue(t);
      p0 = pc;
      @(negedge clk);
      pn = pc;
      repeat (stage - 1) @(negedge clk);
      if (stage == 1) dl_stall = 1'b1; else mem_stall = 1'b1;
      @(negedge clk);
      dl_stall = 1'b0;
      mem_stall = 1'b0;
      wait_issue(t);
      check(pc == p0, req, pc, p0);
      @(negedge clk);
      check(pc == pn + INC, "R9 neighbour", pc, pn + INC);
      wait_issue(t);
      check(pc == p0 + INC, {req, " release"}, pc, p0 + INC);
   endtask

   // R6: busy over three turns, then released
   task automatic t_alu_multi(input int t);
      logic [31:0] p0;
      wait_issue(t);
      p0 = pc;
      for (int r = 0; r < 3; r++) begin
         repeat (3) @(negedge clk);
         alu_busy = 1'b1;
         @(negedge clk);
         alu_busy = 1'b0;
         wait_issue(t);
         check(pc == p0, "R6 replay turn", pc, p0);
      end
      wait_issue(t);
      check(pc == p0 + INC, "R6 done", pc, p0 + INC);
   endtask

   // R7 taken branch; R8 taken branch under replay
   task automatic t_branch(input int t, input logic [31:0] tgt, input bit stalled);
      logic [31:0] p0;
      wait_issue(t);
      p0 = pc;
      repeat (3) @(negedge clk);
      br_taken = 1'b1;
      br_target = tgt;
      mem_stall = stalled;
      @(negedge clk);
      br_taken = 1'b0;
      br_target = '0;
      mem_stall = 1'b0;
      wait_issue(t);
      if (stalled) begin
         check(pc == p0, "R8 branch ignored", pc, p0);
      end else begin
         check(pc == tgt, "R7 branch target", pc, tgt);
         wait_issue(t);
         check(pc == tgt + INC, "R3 after branch", pc, tgt + INC);
      end
   endtask

   // R2 under constant stalls: order kept, every PC frozen
   task automatic t_all_stall();
      logic [31:0] seen [NT];
      wait_issue(0);
      dl_stall = 1'b1;
      mem_stall = 1'b1;
      alu_busy = 1'b1;
      repeat (NT) @(negedge clk);
      for (int t = 0; t < NT; t++) begin
         check(tid == TID_W'(t), "R2 order stalled", 32'(tid), t);
         seen[t] = pc;
         @(negedge clk);
      end
      for (int t = 0; t < NT; t++) begin
         check(tid == TID_W'(t), "R2 order stalled", 32'(tid), t);
         check(pc == seen[t], "R4 frozen", pc, seen[t]);
         @(negedge clk);
      end
      dl_stall = 1'b0;
      mem_stall = 1'b0;
      alu_busy = 1'b0;
      repeat (2 * NT) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_rotation();
      t_stall(2, 1, "R4 deadline replay");
      t_stall(4, 3, "R5 memory replay");
      t_alu_multi(1);
      t_branch(3, 32'h0000_8000, 1'b0);
      t_branch(5, 32'h0000_9000, 1'b1);
      t_all_stall();
      t_rotation();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule